// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block forms the feedback and reference division chain of one frequency-synthesis loop. A behavioural dual-modulus prescaler divides a stream of oscillator ticks by P or P+1. A down-counting swallow counter and a main counter follow it and steer the prescaler's modulus line, so that one comparison pulse `fp` leaves the block every P·N + A oscillator ticks. A separate counter divides a stream of reference ticks by R and emits one reference pulse `fr` per division. Both pulse trains feed a phase comparator outside this block.

All logic runs on one clock. `osc_tick` and `ref_tick` are single-cycle qualifiers marking the edges of the two divided signals. The divide settings are plain control inputs, sampled only at frame boundaries. They carry no handshake, so the block never stalls its input ticks. Dropping `run` puts the chain into power saving. Raising it again loads the current settings and starts a fresh frame.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_n` is low, or on every clock after an edge where `run` is low, `fp`, `fr`, `mod_ctl` and `cfg_err` are 0 and no pulse is produced.
- R2: With `A < N`, consecutive `fp` pulses are exactly P·N + A counted `osc_tick` cycles apart. `fp` rises on the second clock edge after the `osc_tick` that completes the frame.
- R3: `mod_ctl` is 1 for the first A prescaler cycles of each frame and 0 for the rest. With ticks on every clock it is high for A·(P+1) clocks per frame, and it is never high when A = 0.
- R4: `sel_small` = 1 selects P = 64 (64/65). `sel_small` = 0 selects P = 128 (128/129).
- R5: `fr` pulses once every R `ref_tick` events. It appears on the clock edge that takes the R-th tick.
- R6: `cfg_n`, `cfg_a`, `cfg_sel`, `cfg_r` and `sel_small` are used only at a frame boundary of their own chain, or at start-up. A change in mid-frame leaves the running frame's length unchanged.
- R7: If A ≥ N, the frame runs as N = A + 1, which gives P·(A+1) + A ticks. `cfg_err` is then 1 for that frame. It changes only at a frame load.
- R8: `fp` and `fr` are single-clock pulses when R ≥ 5 and N ≥ 5.
- R9: On the first edge with `run` high after power saving or reset, both chains load their settings. With ticks on every clock, the first `fp` is seen P·N + A + 2 sampling cycles after `run` was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = normal operation, 0 = power saving |
| osc_tick | input | 1 | One oscillator edge per asserted cycle |
| ref_tick | input | 1 | One reference edge per asserted cycle |
| cfg_n | input | 11 | Main count N (5..2047) |
| cfg_a | input | 7 | Swallow count A (0..127) |
| cfg_r | input | 14 | Reference ratio R (5..16383) |
| sel_small | input | 1 | 1 = 64/65 prescaler, 0 = 128/129 |
| mod_ctl | output | 1 | Prescaler modulus line, 1 = divide by P+1 |
| fp | output | 1 | Comparison pulse, one per frame |
| fr | output | 1 | Reference pulse, one per R ticks |
| cfg_err | output | 1 | Active frame had A ≥ N |

## Verification
A wrong swallow or main count shows up at `fp` within one frame, as a gap that is off by a multiple of P or by a few ticks. A stuck or late swallow count shows up on `mod_ctl` within the first A prescaler cycles. Configuration that leaks into a running frame makes the frame after a mid-frame change too short or too long. A reference divider fault moves `fr` within R ticks. Because the bench model is compared on every clock, any of these faults is reported on the first cycle where a pulse edge or the modulus level disagrees.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int N_BITS  = 11;
  localparam int A_BITS  = 7;
  localparam int R_BITS  = 14;
  localparam int P_SMALL = 64;
  localparam int P_LARGE = 128;

  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } modulus_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P_LO      = psd_pkg::P_SMALL,
  parameter int P_HI      = psd_pkg::P_LARGE,
  parameter bit FIXED_SEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic enable,
  input  logic sel_lo,
  input  logic mod_plus,
  input  logic osc_tick,
  output logic pulse
);
  localparam int CW = $clog2(P_HI + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base_m1;
  logic [CW-1:0] limit_m1;

  generate
    if (FIXED_SEL) begin : g_fixed
      assign base_m1 = CW'(P_LO - 1);
    end else begin : g_select
      assign base_m1 = sel_lo ? CW'(P_LO - 1) : CW'(P_HI - 1);
    end
  endgenerate

  assign limit_m1 = base_m1 + CW'(mod_plus);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (!run || !enable) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (osc_tick) begin
        if (cnt == limit_m1) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psd_frame_ctr.sv
module psd_frame_ctr #(
  parameter int NW = psd_pkg::N_BITS,
  parameter int AW = psd_pkg::A_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pre_pulse,
  input  logic [NW-1:0] cfg_n,
  input  logic [AW-1:0] cfg_a,
  input  logic          cfg_sel,
  output logic          loaded,
  output logic          sel_act,
  output logic          mod_ctl,
  output logic          fp,
  output logic          cfg_err
);
  import psd_pkg::*;

  logic [NW-1:0] main_cnt;
  logic [AW-1:0] swal_cnt;
  logic [NW-1:0] a_wide;
  logic          bad_cfg;
  logic [NW-1:0] n_eff;
  logic          frame_end;
  modulus_e      modulus;

  assign a_wide    = NW'(cfg_a);
  assign bad_cfg   = (a_wide >= cfg_n);
  assign n_eff     = bad_cfg ? (a_wide + 1'b1) : cfg_n;
  assign frame_end = pre_pulse && (main_cnt <= NW'(1));
  assign modulus   = (swal_cnt != '0) ? MOD_PLUS : MOD_BASE;
  assign mod_ctl   = (modulus == MOD_PLUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      main_cnt <= '0;
      swal_cnt <= '0;
      sel_act  <= 1'b1;
      fp       <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (!run) begin
      loaded   <= 1'b0;
      main_cnt <= '0;
      swal_cnt <= '0;
      sel_act  <= 1'b1;
      fp       <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (!loaded || frame_end) begin
      loaded   <= 1'b1;
      main_cnt <= n_eff;
      swal_cnt <= cfg_a;
      sel_act  <= cfg_sel;
      cfg_err  <= bad_cfg;
      fp       <= loaded;
    end else begin
      fp <= 1'b0;
      if (pre_pulse) begin
        main_cnt <= main_cnt - 1'b1;
        if (swal_cnt != '0) swal_cnt <= swal_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
  parameter int RW = psd_pkg::R_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ref_tick,
  input  logic [RW-1:0] cfg_r,
  output logic          fr
);
  logic [RW-1:0] rcnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt  <= '0;
      armed <= 1'b0;
      fr    <= 1'b0;
    end else if (!run) begin
      rcnt  <= '0;
      armed <= 1'b0;
      fr    <= 1'b0;
    end else if (!armed) begin
      rcnt  <= cfg_r;
      armed <= 1'b1;
      fr    <= 1'b0;
    end else begin
      fr <= 1'b0;
      if (ref_tick) begin
        if (rcnt <= RW'(1)) begin
          rcnt <= cfg_r;
          fr   <= 1'b1;
        end else begin
          rcnt <= rcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int NW        = psd_pkg::N_BITS,
  parameter int AW        = psd_pkg::A_BITS,
  parameter int RW        = psd_pkg::R_BITS,
  parameter int P_LO      = psd_pkg::P_SMALL,
  parameter int P_HI      = psd_pkg::P_LARGE,
  parameter bit FIXED_SEL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          osc_tick,
  input  logic          ref_tick,
  input  logic [NW-1:0] cfg_n,
  input  logic [AW-1:0] cfg_a,
  input  logic [RW-1:0] cfg_r,
  input  logic          sel_small,
  output logic          mod_ctl,
  output logic          fp,
  output logic          fr,
  output logic          cfg_err
);
  logic pre_pulse;
  logic loaded;
  logic sel_act;

  psd_prescaler #(.P_LO(P_LO), .P_HI(P_HI), .FIXED_SEL(FIXED_SEL)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .enable(loaded),
    .sel_lo(sel_act), .mod_plus(mod_ctl), .osc_tick(osc_tick), .pulse(pre_pulse)
  );

  psd_frame_ctr #(.NW(NW), .AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_pulse(pre_pulse),
    .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_sel(sel_small),
    .loaded(loaded), .sel_act(sel_act), .mod_ctl(mod_ctl),
    .fp(fp), .cfg_err(cfg_err)
  );

  psd_ref_div #(.RW(RW)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
    .cfg_r(cfg_r), .fr(fr)
  );
endmodule

// File: rtl/psd_checker.sv
module psd_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic pre_pulse,
  input logic loaded,
  input logic mod_ctl,
  input logic fp,
  input logic fr,
  input logic cfg_err
);
  // R1: power saving clears all outputs on the next edge
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!fp && !fr && !mod_ctl && !cfg_err));

  // R8: comparison pulse is one clock wide
  p_fp_single_r8: assert property (@(posedge clk) disable iff (!rst_n || !run)
    fp |=> !fp);

  // R8: reference pulse is one clock wide
  p_fr_single_r8: assert property (@(posedge clk) disable iff (!rst_n || !run)
    fr |=> !fr);

  // R2: fp only follows a prescaler output pulse
  p_fp_source_r2: assert property (@(posedge clk) disable iff (!rst_n || !run)
    fp |-> $past(pre_pulse));

  // R3: modulus line moves only after a prescaler pulse or a start-up load
  p_mod_moves_r3: assert property (@(posedge clk) disable iff (!rst_n || !run)
    ($past(run) && !$stable(mod_ctl)) |-> ($past(pre_pulse) || $rose(loaded)));

  // R7: error flag changes only at a frame load
  p_err_at_load_r7: assert property (@(posedge clk) disable iff (!rst_n || !run)
    ($past(run) && !$stable(cfg_err)) |-> ($past(pre_pulse) || $rose(loaded)));
endmodule

bind pulse_swallow_divider psd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pre_pulse(pre_pulse), .loaded(loaded),
  .mod_ctl(mod_ctl), .fp(fp), .fr(fr), .cfg_err(cfg_err)
);

// File: tb/sim_pulse_swallow_divider.sv
`timescale 1ns/1ps
module sim_pulse_swallow_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic osc_tick = 1'b0;
  logic ref_tick = 1'b0;
  logic [10:0] cfg_n = 11'd6;
  logic [6:0]  cfg_a = 7'd2;
  logic [13:0] cfg_r = 14'd7;
  logic sel_small = 1'b1;
  logic mod_ctl, fp, fr, cfg_err;

  always #2 clk = ~clk;

  pulse_swallow_divider u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .osc_tick(osc_tick), .ref_tick(ref_tick),
    .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_r(cfg_r), .sel_small(sel_small),
    .mod_ctl(mod_ctl), .fp(fp), .fr(fr), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // tick generation
  bit gap_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int refc = 0;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    osc_tick <= gap_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    ref_tick <= (refc == 2);
    refc <= (refc == 2) ? 0 : refc + 1;
  end

  // behavioural reference model, updated at each edge
  int fNe = 0, fA = 0, fP = 64, fR = 5, pcnt = 0, done = 0, rcnt = 0;
  bit m_loaded = 0, e_fp = 0, e_mod = 0, e_fr = 0, e_err = 0;
  bit pend_rl = 0, pend_mv = 0, pend_mod = 0, old_mod = 0;
  bit started = 0;

  task automatic capture();
    fA  = int'(cfg_a);
    fNe = (int'(cfg_a) >= int'(cfg_n)) ? int'(cfg_a) + 1 : int'(cfg_n);
    fP  = sel_small ? 64 : 128;
    e_err = (int'(cfg_a) >= int'(cfg_n));
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rst_n || !run) begin
      m_loaded = 0; e_fp = 0; e_mod = 0; e_fr = 0; e_err = 0;
      pend_rl = 0; pend_mv = 0; pcnt = 0; done = 0; rcnt = 0;
    end else if (!m_loaded) begin
      m_loaded = 1;
      capture();
      e_mod = (fA > 0); e_fp = 0; e_fr = 0;
      fR = int'(cfg_r); rcnt = 0; pcnt = 0; done = 0;
    end else begin
      old_mod = e_mod; e_fp = 0; e_fr = 0;
      if (pend_rl) begin capture(); e_fp = 1; e_mod = (fA > 0); end
      else if (pend_mv) e_mod = pend_mod;
      pend_rl = 0; pend_mv = 0;
      if (osc_tick) begin
        pcnt++;
        if (pcnt == fP + int'(old_mod)) begin
          pcnt = 0; done++;
          if (done == fNe) begin done = 0; pend_rl = 1; end
          else begin pend_mv = 1; pend_mod = (done < fA); end
        end
      end
      if (ref_tick) begin
        rcnt++;
        if (rcnt == fR) begin rcnt = 0; e_fr = 1; fR = int'(cfg_r); end
      end
    end
  end

  // per-cycle comparison and gap bookkeeping
  int scnt = 0, last_fp = 0, fp_gap = 0, mod_acc = 0, mod_hi = 0, last_fr = 0, fr_gap = 0;
  always @(negedge clk) begin
    scnt++;
    if (started) begin
      chk(fp == e_fp, "R2 fp", fp, e_fp);
      chk(mod_ctl == e_mod, "R3 mod_ctl", mod_ctl, e_mod);
      chk(fr == e_fr, "R5 fr", fr, e_fr);
      chk(cfg_err == e_err, "R7 cfg_err", cfg_err, e_err);
    end
    if (fp) begin fp_gap = scnt - last_fp; last_fp = scnt; mod_hi = mod_acc; mod_acc = 0; end
    if (mod_ctl) mod_acc++;
    if (fr) begin fr_gap = scnt - last_fr; last_fr = scnt; end
  end

  task automatic wait_fp();
    @(negedge clk);
    while (!fp) @(negedge clk);
    #1;
  endtask

  task automatic wait_fr();
    @(negedge clk);
    while (!fr) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input int n, input int a, input int r, input bit s);
    cfg_n = 11'(n); cfg_a = 7'(a); cfg_r = 14'(r); sel_small = s;
  endtask

  task automatic power_up_count(input int exp, input string tag);
    int c = 0;
    @(negedge clk);
    run = 1'b1;
    do begin @(negedge clk); c++; end while (!fp && c < 5000);
    chk(c == exp, tag, c, exp);
    #1;
  endtask

  int seed = 7;
  function automatic int nxt(input int m);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fff) % m;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!fp && !fr && !mod_ctl && !cfg_err, "R1 reset outputs", {fp, fr, mod_ctl, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!fp && !fr && !mod_ctl, "R1 power saving idle", {fp, fr, mod_ctl}, 0);

    // R9: first frame from start-up, N=6 A=2 P=64 -> 386 ticks
    set_cfg(6, 2, 7, 1'b1);
    power_up_count(388, "R9 first fp latency");

    wait_fp();
    chk(fp_gap == 386, "R2 frame 64*6+2", fp_gap, 386);
    chk(mod_hi == 130, "R3 mod high 2*65", mod_hi, 130);
    wait_fr(); wait_fr();
    chk(fr_gap == 21, "R5 fr gap R=7", fr_gap, 21);

    wait_fp();
    repeat (100) @(negedge clk);
    set_cfg(5, 3, 5, 1'b0);
    wait_fp();
    chk(fp_gap == 386, "R6 mid-frame change ignored", fp_gap, 386);
    wait_fp();
    chk(fp_gap == 643, "R4 frame 128*5+3", fp_gap, 643);
    chk(mod_hi == 387, "R3 mod high 3*129", mod_hi, 387);
    wait_fr(); wait_fr();
    chk(fr_gap == 15, "R5 fr gap R=5", fr_gap, 15);

    repeat (50) @(negedge clk);
    set_cfg(5, 9, 5, 1'b1);
    wait_fp();
    chk(fp_gap == 643, "R6 old frame kept", fp_gap, 643);
    chk(cfg_err == 1'b1, "R7 flag set", cfg_err, 1);
    wait_fp();
    chk(fp_gap == 649, "R7 frame 64*10+9", fp_gap, 649);
    chk(mod_hi == 585, "R7 mod high 9*65", mod_hi, 585);

    repeat (50) @(negedge clk);
    set_cfg(7, 0, 6, 1'b1);
    wait_fp();
    chk(fp_gap == 649, "R6 old frame kept", fp_gap, 649);
    chk(cfg_err == 1'b0, "R7 flag cleared", cfg_err, 0);
    wait_fp();
    chk(fp_gap == 448, "R2 frame 64*7", fp_gap, 448);
    chk(mod_hi == 0, "R3 A=0 no mod", mod_hi, 0);

    // irregular ticks with varied settings, model compared each clock
    gap_mode = 1;
    for (int i = 0; i < 12; i++) begin
      wait_fp();
      repeat (nxt(200)) @(negedge clk);
      set_cfg(5 + nxt(8), nxt(12), 5 + nxt(16), 1'(nxt(2)));
    end
    gap_mode = 0;

    // power saving in mid-frame, then restart
    set_cfg(6, 2, 7, 1'b1);
    repeat (3) @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!fp && !fr && !mod_ctl && !cfg_err, "R1 quiet in power saving",
          {fp, fr, mod_ctl, cfg_err}, 0);
    end
    power_up_count(388, "R9 restart latency");
    wait_fp();
    chk(fp_gap == 386, "R2 frame after restart", fp_gap, 386);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule